// File: doc/BRIEF.md
# Two-Way Processor Mailbox Channel

This block connects a host processor port and a parasite processor port. Both ports have the same shape: a 3-bit register select, a chip select, single-cycle read and write strobes, and 8-bit data in each direction. Bytes written by the parasite go through a deep FIFO to the host. Bytes written by the host go through a single-byte latch to the parasite.

Each side reads a status byte that tells it two things: whether data is waiting for it, and whether its own outbound path can take another byte. A byte sitting in the host-to-parasite latch drives an active-low interrupt request to the parasite while an external enable is high. The parasite clears that request by reading the byte.

Both ports run on one shared clock. Read results are registered: each read result appears one cycle after the read strobe. A synchronous clear input empties both directions.

Top module: `mbx_channel`

## Requirements
- R1: Bytes written by the parasite at select 1 come out of host reads at select 1 in the same order. The FIFO holds FIFO_DEPTH bytes (default 24, never fewer than 10).
- R2: A host read at select 0 returns the host status byte. Bit 7 is 1 when the FIFO holds at least one byte. Bit 6 is 1 when the host-to-parasite latch is empty. Bits 5..0 read as 1.
- R3: A parasite read at select 0 returns the parasite status byte. Bit 7 is 1 when the latch holds a byte. Bit 6 is 1 unless all FIFO_DEPTH FIFO entries are occupied. Bits 5..0 read as 1.
- R4: A host write at select 1 to an empty latch stores the byte. A parasite read at select 1 returns that byte and empties the latch.
- R5: A write to a full FIFO or to a full latch is discarded, and the stored bytes are left unchanged. This includes a push to the full FIFO in the same cycle as a host pop.
- R6: A data read from an empty path leaves the read data output at its previous value and removes nothing.
- R7: p_irq_no is low exactly while irq_en_i is 1 and the latch holds a byte. A parasite data read that empties the latch returns p_irq_no to 1.
- R8: clr_i, sampled at a clock edge, empties both the FIFO and the latch.
- R9: A read result appears on the read data output in the cycle after the read strobe, and it is held until the next read.
- R10: An access with chip select low, or with a select value other than 0 or 1, has no effect on either path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of both paths |
| irq_en_i | input | 1 | Enables the parasite interrupt request |
| h_cs_i | input | 1 | Host chip select |
| h_sel_i | input | 3 | Host register select |
| h_rd_i | input | 1 | Host read strobe |
| h_wr_i | input | 1 | Host write strobe |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data (registered) |
| p_cs_i | input | 1 | Parasite chip select |
| p_sel_i | input | 3 | Parasite register select |
| p_rd_i | input | 1 | Parasite read strobe |
| p_wr_i | input | 1 | Parasite write strobe |
| p_wdata_i | input | 8 | Parasite write data |
| p_rdata_o | output | 8 | Parasite read data (registered) |
| p_irq_no | output | 1 | Interrupt request to the parasite, active low |

## Verification
The hardest case to reach is the full-FIFO boundary while both ports are active in the same cycle. The push is refused because the FIFO was full before the edge, but the pop still goes ahead. To reach it, the stimulus fills the FIFO with exactly FIFO_DEPTH parasite writes. It then issues one more parasite write together with a host data read. The scoreboard drains the remaining bytes and confirms that the rejected byte never appears. The bench also checks the empty-read hold, and that the interrupt follows both the latch state and the enable.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned SEL_W    = 3;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DATA = 3'd1;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  initial begin
    p_min_depth_r1: assert (DEPTH >= 10);
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !clr_i) |=> (full_o && $stable(wr_ptr_q)));
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
  p_empty_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !clr_i) |=> $stable(rd_ptr_q));
endmodule

// File: rtl/mbx_latch.sv
module mbx_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          full_o
);
  logic [DW-1:0] data_q;
  logic          full_q;

  assign dout_o = data_q;
  assign full_o = full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (clr_i) begin
      full_q <= 1'b0;
    end else if (full_q) begin
      if (rd_i) full_q <= 1'b0;
    end else if (wr_i) begin
      data_q <= din_i;
      full_q <= 1'b1;
    end
  end

  p_latch_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && wr_i && !clr_i) |=> $stable(data_q));
  p_latch_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !full_q);
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port
  import mbx_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_i,
  input  logic             rd_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             avail_i,
  input  logic             not_full_i,
  input  logic [DW-1:0]    data_i,
  output logic             pop_o,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] rdata_q;
  logic          stat_rd, data_rd;

  assign stat_rd = cs_i && rd_i && (sel_i == SEL_STAT);
  assign data_rd = cs_i && rd_i && (sel_i == SEL_DATA);
  assign pop_o   = data_rd && avail_i;
  assign rdata_o = rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (stat_rd) rdata_q <= {avail_i, not_full_i, {(DW-2){1'b1}}};
    else if (pop_o)   rdata_q <= data_i;
  end

  p_empty_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && !avail_i) |=> $stable(rdata_o));
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |=> $stable(rdata_o));
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned FIFO_DEPTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             irq_en_i,
  input  logic             h_cs_i,
  input  logic [SEL_W-1:0] h_sel_i,
  input  logic             h_rd_i,
  input  logic             h_wr_i,
  input  logic [DW-1:0]    h_wdata_i,
  output logic [DW-1:0]    h_rdata_o,
  input  logic             p_cs_i,
  input  logic [SEL_W-1:0] p_sel_i,
  input  logic             p_rd_i,
  input  logic             p_wr_i,
  input  logic [DW-1:0]    p_wdata_i,
  output logic [DW-1:0]    p_rdata_o,
  output logic             p_irq_no
);
  logic          h_wr_data, p_wr_data;
  logic          h_pop, p_pop;
  logic          fifo_empty, fifo_full, lat_full;
  logic [DW-1:0] fifo_dout, lat_dout;

  assign h_wr_data = h_cs_i && h_wr_i && (h_sel_i == SEL_DATA);
  assign p_wr_data = p_cs_i && p_wr_i && (p_sel_i == SEL_DATA);

  // parasite -> host
  mbx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .clr_i,
    .push_i (p_wr_data),
    .pop_i  (h_pop),
    .din_i  (p_wdata_i),
    .dout_o (fifo_dout),
    .empty_o(fifo_empty),
    .full_o (fifo_full)
  );

  // host -> parasite
  mbx_latch #(.DW(DW)) u_latch (
    .clk_i, .rst_ni, .clr_i,
    .wr_i  (h_wr_data),
    .rd_i  (p_pop),
    .din_i (h_wdata_i),
    .dout_o(lat_dout),
    .full_o(lat_full)
  );

  mbx_rd_port #(.DW(DW)) u_h_rd (
    .clk_i, .rst_ni,
    .cs_i      (h_cs_i),
    .rd_i      (h_rd_i),
    .sel_i     (h_sel_i),
    .avail_i   (!fifo_empty),
    .not_full_i(!lat_full),
    .data_i    (fifo_dout),
    .pop_o     (h_pop),
    .rdata_o   (h_rdata_o)
  );

  mbx_rd_port #(.DW(DW)) u_p_rd (
    .clk_i, .rst_ni,
    .cs_i      (p_cs_i),
    .rd_i      (p_rd_i),
    .sel_i     (p_sel_i),
    .avail_i   (lat_full),
    .not_full_i(!fifo_full),
    .data_i    (lat_dout),
    .pop_o     (p_pop),
    .rdata_o   (p_rdata_o)
  );

  assign p_irq_no = !(irq_en_i && lat_full);

  p_irq_raise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_wr_data && !lat_full && !clr_i && irq_en_i) |=> (!p_irq_no || !irq_en_i));
  p_irq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p_pop && !clr_i) |=> p_irq_no);
  p_deselect_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!h_cs_i && !p_cs_i && !clr_i) |=> ($stable(lat_full) && $stable(fifo_empty)));
endmodule

// File: tb/sim_mbx_channel.sv
module sim_mbx_channel;
  localparam int DEPTH = 24;

  logic       clk = 1'b0, rst_n = 1'b0, clr = 1'b0, irq_en = 1'b0;
  logic       h_cs = 1'b0, h_rd = 1'b0, h_wr = 1'b0;
  logic [2:0] h_sel = 3'd0, p_sel = 3'd0;
  logic       p_cs = 1'b0, p_rd = 1'b0, p_wr = 1'b0;
  logic [7:0] h_wd = 8'h00, p_wd = 8'h00;
  logic [7:0] h_rdata, p_rdata;
  logic       p_irq_n;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mbx_channel #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .irq_en_i(irq_en),
    .h_cs_i(h_cs), .h_sel_i(h_sel), .h_rd_i(h_rd), .h_wr_i(h_wr),
    .h_wdata_i(h_wd), .h_rdata_o(h_rdata),
    .p_cs_i(p_cs), .p_sel_i(p_sel), .p_rd_i(p_rd), .p_wr_i(p_wr),
    .p_wdata_i(p_wd), .p_rdata_o(p_rdata), .p_irq_no(p_irq_n)
  );

  // scoreboard of the parasite->host FIFO
  logic [7:0] exp_q[$];
  logic [7:0] chk_val;
  bit         chk_pending = 1'b0;

  always @(posedge clk) begin
    bit was_full, was_empty, pop_now;
    was_full  = (exp_q.size() == DEPTH);
    was_empty = (exp_q.size() == 0);
    pop_now   = h_cs && h_rd && h_sel == 3'd1 && !was_empty;
    if (!rst_n || clr) begin
      exp_q.delete();
      chk_pending <= 1'b0;
    end else begin
      if (pop_now) chk_val <= exp_q.pop_front();
      chk_pending <= pop_now;
      if (p_cs && p_wr && p_sel == 3'd1 && !was_full) exp_q.push_back(p_wd);
    end
  end

  always @(negedge clk) begin
    if (chk_pending) begin
      checks++;
      if (h_rdata !== chk_val) begin
        failures++;
        $display("FAIL R1 fifo order: actual=%h expected=%h", h_rdata, chk_val);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic p_put(input logic [7:0] b);
    @(negedge clk); p_cs = 1; p_wr = 1; p_sel = 3'd1; p_wd = b;
    @(negedge clk); p_cs = 0; p_wr = 0;
  endtask

  task automatic h_put(input logic [7:0] b, input logic [2:0] s = 3'd1, input logic cs = 1'b1);
    @(negedge clk); h_cs = cs; h_wr = 1; h_sel = s; h_wd = b;
    @(negedge clk); h_cs = 0; h_wr = 0;
  endtask

  task automatic h_get(input logic [2:0] s);
    @(negedge clk); h_cs = 1; h_rd = 1; h_sel = s;
    @(negedge clk); h_cs = 0; h_rd = 0;
  endtask

  task automatic p_get(input logic [2:0] s);
    @(negedge clk); p_cs = 1; p_rd = 1; p_sel = s;
    @(negedge clk); p_cs = 0; p_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    check("R9 reset h_rdata", h_rdata, 8'h00);
    check("R7 reset irq", {7'd0, p_irq_n}, 8'h01);
    h_get(3'd0); check("R2 host status empty", h_rdata, 8'h7F);
    p_get(3'd0); check("R3 parasite status empty", p_rdata, 8'h7F);

    // small traffic, host status shows data
    p_put(8'h11); p_put(8'h22); p_put(8'h33);
    h_get(3'd0); check("R2 host status avail", h_rdata, 8'hFF);
    h_get(3'd1); h_get(3'd1); h_get(3'd1);
    check("R9 held after read", h_rdata, 8'h33);
    h_get(3'd1); check("R6 empty read holds", h_rdata, 8'h33);

    // fill to the boundary
    for (int i = 0; i < DEPTH - 1; i++) p_put(8'h40 + 8'(i));
    p_get(3'd0); check("R3 not full at depth-1", p_rdata, 8'h7F);
    p_put(8'h40 + 8'(DEPTH - 1));
    p_get(3'd0); check("R3 full at depth", p_rdata, 8'h3F);
    p_put(8'hEE); // R5: discarded, scoreboard drops it
    // same-cycle push on full with pop: push rejected
    @(negedge clk); h_cs = 1; h_rd = 1; h_sel = 3'd1; p_cs = 1; p_wr = 1; p_sel = 3'd1; p_wd = 8'hDD;
    @(negedge clk); h_cs = 0; h_rd = 0; p_cs = 0; p_wr = 0;
    p_get(3'd0); check("R5 push on full refused", p_rdata, 8'h7F);
    for (int i = 0; i < DEPTH - 1; i++) h_get(3'd1);
    h_get(3'd1); check("R6 drained hold", h_rdata, 8'h40 + 8'(DEPTH - 1));
    h_get(3'd0); check("R1 drained status", h_rdata, 8'h7F);

    // latch and interrupt
    irq_en = 1;
    h_put(8'hA5);
    check("R7 irq asserted", {7'd0, p_irq_n}, 8'h00);
    h_get(3'd0); check("R2 latch full status", h_rdata, 8'h3F);
    p_get(3'd0); check("R3 latch avail status", p_rdata, 8'hFF);
    h_put(8'h5A); // R5 discarded
    irq_en = 0; #1;
    check("R7 irq gated", {7'd0, p_irq_n}, 8'h01);
    irq_en = 1; #1;
    check("R7 irq regated", {7'd0, p_irq_n}, 8'h00);
    p_get(3'd1); check("R4 latch data / R5 keep", p_rdata, 8'hA5);
    check("R7 irq cleared by read", {7'd0, p_irq_n}, 8'h01);
    p_get(3'd1); check("R6 latch empty read", p_rdata, 8'hA5);

    // deselected / other selects
    h_put(8'h77, 3'd1, 1'b0);
    h_put(8'h78, 3'd3, 1'b1);
    p_get(3'd0); check("R10 no latch effect", p_rdata, 8'h7F);
    check("R10 irq idle", {7'd0, p_irq_n}, 8'h01);

    // clear
    p_put(8'h01); p_put(8'h02); h_put(8'h99);
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    h_get(3'd0); check("R8 host status cleared", h_rdata, 8'h7F);
    p_get(3'd0); check("R8 parasite status cleared", p_rdata, 8'h7F);
    check("R8 irq cleared", {7'd0, p_irq_n}, 8'h01);
    p_put(8'h5C); h_get(3'd1); // R1 after clear: first byte comes out

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule